// File: doc/BRIEF.md
# Incremental ADC Gate and Capture Controller

This block is the digital half of an incremental or delta-sigma converter. The analog comparators deliver one bit per clock. The block opens a conversion window from one of sixteen timer outputs, usually a PWM whose high time equals the conversion period. While that window is high it counts the ones seen on one chosen comparator bit.

A second timer output, chosen separately from the first twelve sources, marks the end of a conversion. On its rising edge, or on its falling edge if software asks for that, the running count moves into a result register and the counter starts over. A nonzero decimation rate on a side input overrides the capture timer: an internal counter then issues the capture strobe every `dec_rate` clocks.

Software sets everything through two 8-bit control registers on a small register bus. It reads the 16-bit result through the same bus. A valid flag is set on each capture and cleared when software reads the low byte of the result.

Top module: `adcg_top`

## Requirements
- R1: After reset, both control registers read 0x00, the result reads 0x0000 and `result_valid` is 0.
- R2: Bus addresses: 0 is control word A (all 8 bits writable and readable), 1 is control word B (bits 6:0 writable; bit 7 always reads 0), 2 is result bits 7:0 and 3 is result bits 15:8. `bus_rdata` follows `bus_addr` combinationally. A write takes effect at the clock edge where `bus_wr` is high.
- R3: The gate index is {B[5:3], A[3]}. The count grows by one per clock only while the selected source is high and the chosen comparator bit is 1. Each source passes through a two-stage synchronizer, so a window of N clocks at the pin yields a count of N.
- R4: Column enables are A[4]..A[7] for standard columns 0..3 and A[1], A[2] for type-E columns 0 and 1. The lowest enabled column in the order std0, std1, std2, std3, E0, E1 alone drives the count. With no enable set, nothing is counted.
- R5: The capture index is {B[2:0], A[0]}. Indices 0..11 pick source 0..11. Indices 12..15 pick no source and never capture while the decimation rate is 0.
- R6: With B[6]=0, a capture follows a rising edge of the selected source. With B[6]=1, it follows a falling edge. A capture appears on the third clock edge after the pin changes.
- R7: On a capture, the result takes the count including the current clock's increment, and the count restarts from zero.
- R8: When `dec_rate` is nonzero, the timer selection is ignored and a capture occurs once every `dec_rate` clocks.
- R9: The count saturates at 0xFFFF and does not wrap.
- R10: `result_valid` is set by a capture and cleared by a bus read of address 2. A read of address 3 leaves it alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| blk_src | input | 16 | Digital timer outputs, asynchronous |
| cmp_std | input | 4 | Standard column comparator bits |
| cmp_e | input | 2 | Type-E column comparator bits |
| dec_rate | input | 8 | Decimation rate, 0 selects timer capture |
| result | output | 16 | Captured count |
| result_valid | output | 1 | New result not yet read |

## Verification
A wrong source index, edge polarity or column priority does not show until the next capture. It then appears as a wrong `result` value, or as a capture that is missing or extra. A cycle-level predictor in the bench flags it on the half cycle after the capture edge. A counter that is off by one, or that keeps counting through a capture, shows the same way, one conversion late. A saturation fault needs a window longer than 65535 clocks before it becomes visible. Directed reads of fixed windows pin the absolute values so that they do not depend on the predictor alone.

// File: rtl/adcg_pkg.sv
package adcg_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    A_CTLA  = 2'd0,
    A_CTLB  = 2'd1,
    A_RESLO = 2'd2,
    A_RESHI = 2'd3
  } adcg_addr_e;

  // control word A fields
  localparam int A_CAP_LSB  = 0;
  localparam int A_GATE_LSB = 3;
  // control word B fields
  localparam int B_FALL     = 6;
endpackage

// File: rtl/adcg_rst_sync.sv
module adcg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q, stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= stg_d;
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/adcg_regs.sv
module adcg_regs
  import adcg_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [RES_W-1:0] result,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] ctla,
  output logic [6:0]       ctlb,
  output logic             rd_clr
);
  logic [REG_W-1:0] ctla_d;
  logic [6:0]       ctlb_d;
  logic             wr_a, wr_b;
  logic [15:0]      res16;

  assign res16 = 16'(result);
  assign wr_a  = wr && (addr == A_CTLA);
  assign wr_b  = wr && (addr == A_CTLB);
  assign rd_clr = rd && (addr == A_RESLO);

  always_comb begin
    ctla_d = ctla;
    ctlb_d = ctlb;
    if (wr_a) ctla_d = wdata;
    if (wr_b) ctlb_d = wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla <= '0;
      ctlb <= '0;
    end else begin
      ctla <= ctla_d;
      ctlb <= ctlb_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTLA:  rdata = ctla;
      A_CTLB:  rdata = {1'b0, ctlb};
      A_RESLO: rdata = res16[7:0];
      default: rdata = res16[15:8];
    endcase
  end

  // R2: a write to A lands on the next edge
  a_r2_write_a: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> ctla == $past(wdata));
endmodule

// File: rtl/adcg_timing.sv
module adcg_timing #(
  parameter int NUM_SRC = 16,
  parameter int NUM_CAP = 12,
  parameter int RATE_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic [IDX_W-1:0]  gate_idx,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic              fall_edge,
  input  logic [RATE_W-1:0] dec_rate,
  output logic              gate_open,
  output logic              cap_stb
);
  localparam logic [IDX_W-1:0] CAP_LIM = IDX_W'(NUM_CAP);

  logic [NUM_SRC-1:0] s1_q, s2_q, s1_d, s2_d;
  logic               prev_q, prev_d;
  logic               tsel, tedge, rate_hit;
  logic [RATE_W-1:0]  cnt_q, cnt_d;

  // two-stage synchronizer, one flop pair per source
  always_comb begin
    s1_d = src;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign gate_open = s2_q[gate_idx];

  // capture timer select; upper indices reach no source
  always_comb begin
    tsel = 1'b0;
    if (cap_idx < CAP_LIM) tsel = s2_q[cap_idx];
  end

  assign prev_d = tsel;
  assign tedge  = fall_edge ? (prev_q & ~tsel) : (~prev_q & tsel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // decimation rate counter
  assign rate_hit = (dec_rate != '0) && (cnt_q >= RATE_W'(dec_rate - 1'b1));

  always_comb begin
    if (dec_rate == '0) cnt_d = '0;
    else if (rate_hit)  cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cap_stb = (dec_rate != '0) ? rate_hit : tedge;

  // R8: counter stays inside the programmed period
  a_r8_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rate != '0 && $past(dec_rate) == dec_rate) |-> cnt_q < dec_rate);

  // R5: no strobe from an index that reaches no source
  a_r5_no_source: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rate == '0 && cap_idx >= CAP_LIM && $past(cap_idx) >= CAP_LIM) |-> !cap_stb);

  // R6: a rising-mode strobe sees the timer high, a falling-mode one sees it low
  a_r6_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rate == '0 && cap_stb) |-> (tsel == !fall_edge));
endmodule

// File: rtl/adcg_accum.sv
module adcg_accum #(
  parameter int NCOL  = 6,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCOL-1:0]  col_en,
  input  logic [NCOL-1:0]  cmp,
  input  logic             gate_open,
  input  logic             cap_stb,
  input  logic             rd_clr,
  output logic [ACC_W-1:0] result,
  output logic             valid
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [NCOL-1:0]  pick;
  logic             bit_sel, inc;
  logic [ACC_W-1:0] acc_q, acc_d, sum, res_d;
  logic             valid_d;

  // lowest enabled column wins
  always_comb begin
    pick = '0;
    for (int i = NCOL - 1; i >= 0; i--) begin
      if (col_en[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  assign bit_sel = |(pick & cmp);
  assign inc     = gate_open & bit_sel;

  always_comb begin
    sum = acc_q;
    if (inc && acc_q != ACC_MAX) sum = acc_q + 1'b1;
  end

  always_comb begin
    acc_d   = sum;
    res_d   = result;
    valid_d = valid;
    if (rd_clr) valid_d = 1'b0;
    if (cap_stb) begin
      acc_d   = '0;
      res_d   = sum;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      result <= '0;
      valid  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      result <= res_d;
      valid  <= valid_d;
    end
  end

  // R4: at most one column feeds the count
  a_r4_one_col: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  // R9: a full count holds until captured
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == ACC_MAX && !cap_stb) |=> acc_q == ACC_MAX);

  // R3: a closed gate freezes the count
  a_r3_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !cap_stb) |=> acc_q == $past(acc_q));

  // R10: every capture raises the flag
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> valid);
endmodule

// File: rtl/adcg_top.sv
module adcg_top
  import adcg_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_CAP = 12,
  parameter int ACC_W   = 16,
  parameter int RATE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0] blk_src,
  input  logic [3:0]         cmp_std,
  input  logic [1:0]         cmp_e,
  input  logic [RATE_W-1:0]  dec_rate,
  output logic [ACC_W-1:0]   result,
  output logic               result_valid
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int NCOL  = 6;

  logic             rst_i;
  logic [REG_W-1:0] ctla;
  logic [6:0]       ctlb;
  logic             rd_clr, gate_open, cap_stb;
  logic [IDX_W-1:0] gate_idx, cap_idx;
  logic [NCOL-1:0]  col_en, cmp_all;

  adcg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  adcg_regs #(.RES_W(ACC_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_i),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .result (result),
    .rdata  (bus_rdata),
    .ctla   (ctla),
    .ctlb   (ctlb),
    .rd_clr (rd_clr)
  );

  assign gate_idx = IDX_W'({ctlb[5:3], ctla[A_GATE_LSB]});
  assign cap_idx  = IDX_W'({ctlb[2:0], ctla[A_CAP_LSB]});
  assign col_en   = {ctla[2], ctla[1], ctla[7], ctla[6], ctla[5], ctla[4]};
  assign cmp_all  = {cmp_e, cmp_std};

  adcg_timing #(
    .NUM_SRC (NUM_SRC),
    .NUM_CAP (NUM_CAP),
    .RATE_W  (RATE_W)
  ) u_timing (
    .clk       (clk),
    .rst_n     (rst_i),
    .src       (blk_src),
    .gate_idx  (gate_idx),
    .cap_idx   (cap_idx),
    .fall_edge (ctlb[B_FALL]),
    .dec_rate  (dec_rate),
    .gate_open (gate_open),
    .cap_stb   (cap_stb)
  );

  adcg_accum #(
    .NCOL  (NCOL),
    .ACC_W (ACC_W)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_i),
    .col_en    (col_en),
    .cmp       (cmp_all),
    .gate_open (gate_open),
    .cap_stb   (cap_stb),
    .rd_clr    (rd_clr),
    .result    (result),
    .valid     (result_valid)
  );
endmodule

// File: tb/test_adcg_top.sv
`timescale 1ns/1ps
module test_adcg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [15:0] blk_src = 16'd0;
  logic [3:0]  cmp_std = 4'd0;
  logic [1:0]  cmp_e = 2'd0;
  logic [7:0]  dec_rate = 8'd0;
  logic [15:0] result;
  logic        result_valid;

  int total = 0, bad = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  adcg_top i_adcg_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .blk_src(blk_src), .cmp_std(cmp_std), .cmp_e(cmp_e),
    .dec_rate(dec_rate), .result(result), .result_valid(result_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- predictor: pushes expected results -------------
  logic [15:0] m_s1, m_s2, m_acc;
  logic        m_prev;
  logic [7:0]  m_a, m_b, m_cnt;
  logic [15:0] exp_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_acc <= '0; m_prev <= 1'b0;
      m_a <= '0; m_b <= '0; m_cnt <= '0;
    end else begin : mdl
      logic [3:0]  gi, ci;
      logic        g, t, e, cap, b;
      logic [5:0]  en, cv;
      logic [15:0] s;
      gi = {m_b[5:3], m_a[3]};
      ci = {m_b[2:0], m_a[0]};
      g  = m_s2[gi];
      t  = (ci < 4'd12) ? m_s2[ci] : 1'b0;
      e  = m_b[6] ? (m_prev && !t) : (!m_prev && t);
      cap = (dec_rate != 0) ? (m_cnt >= dec_rate - 8'd1) : e;
      en = {m_a[2], m_a[1], m_a[7], m_a[6], m_a[5], m_a[4]};
      cv = {cmp_e, cmp_std};
      b  = 1'b0;
      for (int i = 5; i >= 0; i--) if (en[i]) b = cv[i];
      s = m_acc;
      if (g && b && m_acc != 16'hFFFF) s = m_acc + 16'd1;
      if (cap) begin
        exp_q.push_back(s);
        m_acc <= '0;
      end else m_acc <= s;
      m_cnt <= (dec_rate == 0 || cap) ? 8'd0 : m_cnt + 8'd1;
      m_prev <= t;
      m_s1 <= blk_src;
      m_s2 <= m_s1;
      if (bus_wr && bus_addr == 2'd0) m_a <= bus_wdata;
      if (bus_wr && bus_addr == 2'd1) m_b <= {1'b0, bus_wdata[6:0]};
    end
  end

  // ---------------- monitor: compares each capture -----------------
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] ex;
      ex = exp_q.pop_front();
      chk(result == ex, {phase, "/R7 capture value"}, result, ex);
      chk(result_valid == 1'b1, "R10 flag after capture", result_valid, 1);
    end
  end

  // ---------------- driver tasks ----------------------------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic gate_for(input int n);
    @(negedge clk); blk_src[2] = 1'b1;
    repeat (n) @(negedge clk);
    blk_src[2] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); blk_src[idx] = 1'b1;
    repeat (3) @(negedge clk);
    blk_src[idx] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset values
    rd(2'd0, d); chk(d == 8'h00, "R1 ctl A", d, 0);
    rd(2'd1, d); chk(d == 8'h00, "R1 ctl B", d, 0);
    rd(2'd3, d); chk(d == 8'h00, "R1 result hi", d, 0);
    chk(result == 16'h0 && result_valid == 1'b0, "R1 result/valid", {result_valid, result}, 0);

    // R2 register readback
    phase = "R2";
    wr(2'd0, 8'hA4); rd(2'd0, d); chk(d == 8'hA4, "R2 ctl A readback", d, 8'hA4);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk(d == 8'h7F, "R2 ctl B bit7 zero", d, 8'h7F);

    // R3 gate src2 (B=0x0A), capture src5 rising, std col0
    phase = "R3";
    wr(2'd0, 8'h11); wr(2'd1, 8'h0A);
    cmp_std = 4'b0001;
    pulse(5);
    gate_for(10);
    pulse(5);
    rd(2'd3, d); chk(d == 8'h00, "R3 window count hi", d, 0);
    rd(2'd2, d); chk(d == 8'd10, "R3 window count of 10", d, 10);
    @(negedge clk); chk(result_valid == 1'b0, "R10 read of addr2 clears", result_valid, 0);

    // R6 falling edge mode
    phase = "R6";
    wr(2'd1, 8'h4A);
    gate_for(5);
    @(negedge clk); blk_src[5] = 1'b1;
    repeat (5) @(negedge clk);
    chk(result_valid == 1'b0, "R6 no capture on rise in falling mode", result_valid, 0);
    blk_src[5] = 1'b0;
    repeat (5) @(negedge clk);
    chk(result_valid == 1'b1 && result == 16'd5, "R6 capture on fall", result, 5);
    rd(2'd3, d);
    chk(result_valid == 1'b1, "R10 read of addr3 keeps flag", result_valid, 1);
    rd(2'd2, d);

    // R4 column priority: std2 and E1 enabled, std2 wins
    phase = "R4";
    wr(2'd0, 8'h45);
    cmp_std = 4'b0000; cmp_e = 2'b10;
    gate_for(6); pulse(5);
    chk(result == 16'd0, "R4 std2 outranks E1", result, 0);
    cmp_std = 4'b0100; cmp_e = 2'b00;
    gate_for(6); pulse(5);
    chk(result == 16'd6, "R4 std2 counts", result, 6);
    wr(2'd0, 8'h03); cmp_std = 4'b1111; cmp_e = 2'b01;
    gate_for(7); pulse(5);
    chk(result == 16'd7, "R4 E0 only", result, 7);
    wr(2'd0, 8'h01);
    gate_for(7); pulse(5);
    chk(result == 16'd0, "R4 no column enabled", result, 0);
    rd(2'd2, d);

    // R5 capture index 12 reaches nothing
    phase = "R5";
    wr(2'd0, 8'h10); wr(2'd1, 8'h0E);
    gate_for(4);
    pulse(12); pulse(5);
    chk(result_valid == 1'b0, "R5 index 12 never captures", result_valid, 0);

    // R8 decimation overrides the timer
    phase = "R8";
    blk_src[2] = 1'b1;
    @(negedge clk); dec_rate = 8'd5;
    repeat (23) @(negedge clk);
    chk(result_valid == 1'b1, "R8 rate counter captures", result_valid, 1);
    @(negedge clk); dec_rate = 8'd0;
    blk_src[2] = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd2, d);

    // R9 saturation
    phase = "R9";
    wr(2'd0, 8'h11); wr(2'd1, 8'h0A);
    cmp_std = 4'b0001;
    pulse(5);
    gate_for(66000);
    pulse(5);
    chk(result == 16'hFFFF, "R9 saturates", result, 16'hFFFF);
    rd(2'd3, d); chk(d == 8'hFF, "R2 result high byte", d, 8'hFF);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 no pending capture", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule